// File: doc/BRIEF.md
# DS3 C-bit Path Parity Monitor

This block sits behind a DS3 receive framer and checks end-to-end path parity on a C-bit parity framed stream. Line bits arrive one per accepted transfer on a valid/ready input. The framer supplies a lock level and a marker on the first bit of each M-frame. The block keeps its own bit position inside the 4760-bit M-frame and folds every payload bit into a running parity. At the end of each frame it holds that parity for one full frame.

When the three parity-carrying C-bits of the next frame have arrived, it takes their majority and compares it with the held value. A mismatch raises a one-cycle error pulse. A framing-error pulse from the framer is also treated as an error event. Every event adds one to a saturating 16-bit counter, which software or a performance monitor can clear synchronously.

The input never applies back-pressure. `bit_ready` is high from the first clock after reset is released, and a bit is consumed on every cycle in which `bit_valid` and `bit_ready` are both high. Cycles with `bit_valid` low leave the frame position and the parity untouched.

Top module: `ds3_cpar_mon`

## Requirements
- R1: `bit_ready` is high in every cycle after the first clock edge following reset release. A cycle with `bit_valid` low neither advances the frame position nor alters parity.
- R2: The M-frame is 7 subframes of 8 blocks of 85 bits. Bit 0 of each block is overhead and the other 84 are payload. The computed parity is the XOR of the 4704 payload bits, so it is 1 when the payload holds an odd number of ones. Overhead bits never contribute.
- R3: The received parity bits are the overhead bits of blocks 2, 4 and 6 (counting from 0) of subframe 2 (counting from 0). These sit at frame bit offsets 1530, 1700 and 1870. The received value is the majority of the three, so one corrupted bit does not cause an error.
- R4: The majority value of a frame is compared with the parity computed over the previous frame. A mismatch drives `err_pulse` high for exactly the cycle after the bit at offset 1870 is accepted.
- R5: No comparison is made in the first M-frame after lock is acquired, or after a realignment.
- R6: A `frm_err` pulse produces `err_pulse` in the next cycle. When it coincides with a parity mismatch, the two together count as a single event.
- R7: `err_count` rises by exactly one in the same cycle as each `err_pulse`, and it holds at 65535 rather than wrapping.
- R8: `cnt_clr` sets `err_count` to 0 on the next cycle, even if an event occurs in the same cycle.
- R9: While `frame_lock` is low, input bits are ignored and the held parity is discarded.
- R10: `frame_start` marks the accepted bit as frame offset 0. If it arrives while the tracked position is not at offset 0, the held parity is discarded (realignment).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | A line bit is offered |
| bit_ready | output | 1 | Block accepts the offered bit (never deasserted after reset) |
| bit_data | input | 1 | Line bit value |
| frame_lock | input | 1 | Framer reports M-frame alignment |
| frame_start | input | 1 | Offered bit is the first bit of an M-frame |
| frm_err | input | 1 | Framer reports a framing error event (one-cycle pulse) |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| err_pulse | output | 1 | One-cycle C-bit parity error event |
| err_count | output | 16 | Saturating error event count |

## Verification
The per-cycle properties cover the counter and handshake side. They check that ready stays high once out of reset, that a framing-error pulse is always followed by an error pulse, and that each pulse moves the count by exactly one. They also check that the count never steps by more than one, sticks at its maximum, returns to zero after a clear, and that no pulse appears while unlocked without a framing error. The parity itself can only be shown by scenarios with known frame contents. These include the one-frame delay between a frame and its check bits, majority voting with one, two and three inverted check bits, and the skipped comparison after lock acquisition and after realignment. They also include invalid gaps inside a frame, coincident events, and saturation after more than 65535 events.

// File: rtl/ds3_cpar_pkg.sv
package ds3_cpar_pkg;
  // default frame geometry
  parameter int BLOCK_BITS   = 85;
  parameter int SF_BLOCKS    = 8;
  parameter int MF_SUBFRAMES = 7;
  // subframe and block slots of the parity-carrying C-bits (behavioural positions)
  parameter int CP_SUBFRAME  = 2;
  parameter int CP_BLK_A     = 2;
  parameter int CP_BLK_B     = 4;
  parameter int CP_BLK_C     = 6;

  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2,
    SLOT_C    = 2'd3
  } cp_slot_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cpm_position.sv
module cpm_position
  import ds3_cpar_pkg::*;
#(
  parameter int BLK_BITS = BLOCK_BITS,
  parameter int BLKS     = SF_BLOCKS,
  parameter int SFS      = MF_SUBFRAMES,
  parameter int CP_SF    = CP_SUBFRAME
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lock,
  input  logic     adv,
  input  logic     start,
  output logic     is_ovh,
  output logic     is_last,
  output logic     at_zero,
  output cp_slot_t cp_slot
);
  localparam int BW = $clog2(BLK_BITS);
  localparam int KW = $clog2(BLKS);
  localparam int SW = $clog2(SFS);

  logic [BW-1:0] bit_q, bit_e;
  logic [KW-1:0] blk_q, blk_e;
  logic [SW-1:0] sf_q, sf_e;
  logic          bit_end, blk_end, sf_end;

  always_comb begin
    bit_e   = start ? '0 : bit_q;
    blk_e   = start ? '0 : blk_q;
    sf_e    = start ? '0 : sf_q;
    bit_end = (bit_e == BW'(BLK_BITS - 1));
    blk_end = (blk_e == KW'(BLKS - 1));
    sf_end  = (sf_e == SW'(SFS - 1));
    at_zero = (bit_q == '0) && (blk_q == '0) && (sf_q == '0);
    is_ovh  = (bit_e == '0);
    is_last = bit_end && blk_end && sf_end;
    cp_slot = SLOT_NONE;
    if (is_ovh && sf_e == SW'(CP_SF)) begin
      if (blk_e == KW'(CP_BLK_A))      cp_slot = SLOT_A;
      else if (blk_e == KW'(CP_BLK_B)) cp_slot = SLOT_B;
      else if (blk_e == KW'(CP_BLK_C)) cp_slot = SLOT_C;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lock) begin
      bit_q <= '0;
      blk_q <= '0;
      sf_q  <= '0;
    end else if (adv) begin
      if (!bit_end) begin
        bit_q <= bit_e + 1'b1;
        blk_q <= blk_e;
        sf_q  <= sf_e;
      end else begin
        bit_q <= '0;
        if (!blk_end) begin
          blk_q <= blk_e + 1'b1;
          sf_q  <= sf_e;
        end else begin
          blk_q <= '0;
          sf_q  <= sf_end ? '0 : sf_e + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpm_parity.sv
module cpm_parity
  import ds3_cpar_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lock,
  input  logic     adv,
  input  logic     start,
  input  logic     data,
  input  logic     is_ovh,
  input  logic     is_last,
  input  logic     at_zero,
  input  cp_slot_t cp_slot,
  output logic     mismatch
);
  logic trk_q, acc_q, held_par_q, held_ok_q, cpa_q, cpb_q;
  logic active, base, folded;

  always_comb begin
    active   = adv && lock && (trk_q || start);
    base     = start ? 1'b0 : acc_q;
    folded   = base ^ (data & ~is_ovh);
    mismatch = active && (cp_slot == SLOT_C) && held_ok_q &&
               (maj3(cpa_q, cpb_q, data) != held_par_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_q      <= 1'b0;
      acc_q      <= 1'b0;
      held_par_q <= 1'b0;
      held_ok_q  <= 1'b0;
      cpa_q      <= 1'b0;
      cpb_q      <= 1'b0;
    end else if (!lock) begin
      trk_q     <= 1'b0;
      acc_q     <= 1'b0;
      held_ok_q <= 1'b0;
    end else if (active) begin
      trk_q <= 1'b1;
      if (start && trk_q && !at_zero) held_ok_q <= 1'b0;
      if (is_last) begin
        held_par_q <= folded;
        held_ok_q  <= 1'b1;
        acc_q      <= 1'b0;
      end else begin
        acc_q <= folded;
      end
      if (cp_slot == SLOT_A) cpa_q <= data;
      if (cp_slot == SLOT_B) cpb_q <= data;
    end
  end
endmodule

// File: rtl/cpm_errcnt.sv
module cpm_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             event_in,
  input  logic             clr,
  output logic             pulse,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      count <= '0;
    end else begin
      pulse <= event_in;
      if (clr)                               count <= '0;
      else if (event_in && count != CNT_MAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/ds3_cpar_mon.sv
module ds3_cpar_mon
  import ds3_cpar_pkg::*;
#(
  parameter int BLK_BITS = BLOCK_BITS,
  parameter int BLKS     = SF_BLOCKS,
  parameter int SFS      = MF_SUBFRAMES,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  output logic             bit_ready,
  input  logic             bit_data,
  input  logic             frame_lock,
  input  logic             frame_start,
  input  logic             frm_err,
  input  logic             cnt_clr,
  output logic             err_pulse,
  output logic [CNT_W-1:0] err_count
);
  logic     ready_q, adv, is_ovh, is_last, at_zero, mismatch;
  cp_slot_t cp_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign bit_ready = ready_q;
  assign adv       = bit_valid && ready_q && frame_lock;

  cpm_position #(
    .BLK_BITS(BLK_BITS), .BLKS(BLKS), .SFS(SFS), .CP_SF(CP_SUBFRAME)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .lock(frame_lock), .adv(adv),
    .start(frame_start), .is_ovh(is_ovh), .is_last(is_last),
    .at_zero(at_zero), .cp_slot(cp_slot)
  );

  cpm_parity u_par (
    .clk(clk), .rst_n(rst_n), .lock(frame_lock), .adv(adv),
    .start(frame_start), .data(bit_data), .is_ovh(is_ovh),
    .is_last(is_last), .at_zero(at_zero), .cp_slot(cp_slot),
    .mismatch(mismatch)
  );

  cpm_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .event_in(mismatch | frm_err),
    .clr(cnt_clr), .pulse(err_pulse), .count(err_count)
  );
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_ready,
  input logic             frame_lock,
  input logic             frm_err,
  input logic             cnt_clr,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  a_r1_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> bit_ready);

  a_r6_frmerr_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err |=> err_pulse);

  a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (err_count == $past(err_count) ||
                  err_count == $past(err_count) + CNT_W'(1)));

  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == TOP && !cnt_clr) |=> err_count == TOP);

  a_r4_pulse_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && !$past(cnt_clr) && $past(err_count) != TOP) |->
      err_count == $past(err_count) + CNT_W'(1));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> err_count == '0);

  a_r9_unlocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_lock && !frm_err) |=> !err_pulse);
endmodule

bind ds3_cpar_mon cpm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_ready(bit_ready), .frame_lock(frame_lock),
  .frm_err(frm_err), .cnt_clr(cnt_clr), .err_pulse(err_pulse),
  .err_count(err_count)
);

// File: tb/tb_ds3_cpar_mon.sv
module tb_ds3_cpar_mon;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;
  localparam int SUBF  = 680;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bit_valid = 0, bit_data = 0, frame_lock = 0, frame_start = 0;
  logic        frm_err = 0, cnt_clr = 0;
  logic        bit_ready, err_pulse;
  logic [15:0] err_count;

  int errors = 0, checks = 0;
  bit done = 0;

  logic        q_pulse[$];
  logic [15:0] q_cnt[$];
  string       q_tag[$];

  logic [15:0] m_cnt = 0;
  bit          m_ok = 0;
  logic        m_par = 0;
  logic        lock_val = 0;
  string       cur_req = "R1";

  always #10 clk = ~clk;

  ds3_cpar_mon dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .frame_lock(frame_lock), .frame_start(frame_start),
    .frm_err(frm_err), .cnt_clr(cnt_clr), .err_pulse(err_pulse),
    .err_count(err_count)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues what the outputs must show
  task automatic drive(input logic v, input logic d, input logic st,
                       input logic fe, input logic cl, input logic ev);
    @(negedge clk);
    bit_valid = v; bit_data = d; frame_start = st; frm_err = fe;
    cnt_clr = cl; frame_lock = lock_val;
    if (cl) m_cnt = 0;
    else if (ev && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
    q_pulse.push_back(ev);
    q_cnt.push_back(m_cnt);
    q_tag.push_back(cur_req);
  endtask

  // monitor: compares one queued item per clock, a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_pulse.size() > 0) begin
        logic        ep;
        logic [15:0] ec;
        string       tg;
        ep = q_pulse.pop_front();
        ec = q_cnt.pop_front();
        tg = q_tag.pop_front();
        check(err_pulse === ep, {tg, " err_pulse"}, int'(err_pulse), int'(ep));
        check(err_count === ec, {tg, " err_count"}, int'(err_count), int'(ec));
      end
    end
  end

  function automatic int slot_of(input int p);
    if (p / SUBF != 2 || p % BLK != 0) return 0;
    case ((p % SUBF) / BLK)
      2: return 1;
      4: return 2;
      6: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic maj(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // sends n bits of a frame; flips = how many check bits are inverted
  task automatic send_bits(input int n, input int flips, input int ferr_at,
                           input bit gaps, output logic par);
    logic c1, c2;
    c1 = 0; c2 = 0; par = 0;
    for (int p = 0; p < n; p++) begin
      logic d, ev;
      int   s;
      s = slot_of(p);
      if (s != 0) begin
        d = (m_ok ? m_par : logic'($urandom % 2)) ^ (s <= flips);
        if (s == 1) c1 = d;
        if (s == 2) c2 = d;
      end else begin
        d = logic'($urandom % 2);
        if (p % BLK != 0) par = par ^ d;
      end
      ev = (p == ferr_at);
      if (s == 3 && m_ok && maj(c1, c2, d) != m_par) ev = 1;
      drive(1, d, p == 0, p == ferr_at, 0, ev);
      if (gaps && p % 7 == 6) drive(0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic send_frame(input int flips, input int ferr_at, input bit gaps);
    logic par;
    send_bits(FRAME, flips, ferr_at, gaps, par);
    m_ok = 1;
    m_par = par;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    logic par;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    @(posedge clk); #5;
    // R1: ready after reset, reset state of outputs
    check(bit_ready === 1'b1, "R1 bit_ready", int'(bit_ready), 1);
    check(err_pulse === 1'b0, "R1 reset err_pulse", int'(err_pulse), 0);
    check(err_count === 16'd0, "R1 reset err_count", int'(err_count), 0);

    lock_val = 1;
    cur_req = "R5 first frame"; send_frame(3, -1, 0);     // no compare
    cur_req = "R2 clean";       send_frame(0, -1, 0);
    cur_req = "R3 one flip";    send_frame(1, -1, 0);     // majority masks it
    cur_req = "R4 two flips";   send_frame(2, -1, 0);     // error at 1870
    cur_req = "R1 gaps";        send_frame(0, -1, 1);     // idle cycles inside
    cur_req = "R4 after gaps";  send_frame(3, -1, 0);
    cur_req = "R6 framing err"; send_frame(0, 300, 0);
    cur_req = "R6 coincident";  send_frame(3, 1870, 0);   // single event

    cur_req = "R9 unlock";
    lock_val = 0;
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 0, 0);  // ignored bits
    m_ok = 0;
    lock_val = 1;
    cur_req = "R5 reacquire";   send_frame(3, -1, 0);
    cur_req = "R4 after lock";  send_frame(2, -1, 0);

    cur_req = "R10 realign";
    send_bits(1000, 0, -1, 0, par);
    m_ok = 0;
    send_frame(3, -1, 0);                                 // held parity dropped
    cur_req = "R2 resumed";     send_frame(0, -1, 0);

    cur_req = "R7 saturate";
    lock_val = 0;
    for (int i = 0; i < 65540; i++) drive(0, 0, 0, 1, 0, 1);
    cur_req = "R8 clear wins";
    drive(0, 0, 0, 1, 1, 1);
    drive(0, 0, 0, 0, 0, 0);
    cur_req = "R8 count after clear";
    drive(0, 0, 0, 1, 0, 1);
    drive(0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    @(posedge clk); #6;
    done = 1;
    finish_run();
  end
endmodule